// File: doc/BRIEF.md
# Selectable Performance Event Counter

This block is one counter of a performance-monitoring unit. The CPU pipeline, the caches and the address-translation buffers feed it a vector of raw status levels and one-cycle pulses. A select field in the control register picks one of twenty-six event codes, and the counter then advances by the rule that code defines. Some codes count occurrences: each time a condition begins, the count goes up by one. Other codes count duration: the count goes up on every cycle the condition holds. Several conditions can be selected under two codes, one for each of these two modes.

Software uses a two-register port. The control register holds the select field, the enable bit, the sticky overflow flag and a clear command. The count register can be read and loaded. Two cycle-count codes for cache activity stop charging a write once it has been handed to the write buffer. Select codes above 0x19 are reserved and never advance the count.

Top module: `perf_event_counter`

## Requirements
- R1: Raw vector bit map: 0 icache miss, 1 fetch stall, 2 data hazard, 3 ITLB miss, 4 DTLB miss, 5 branch, 6 mispredict, 7 retire, 8 write buffer full, 9 read miss stall, 10 write busy, 11 read busy, 12 write in buffer, 13 read stall, 14 write stall, 15 dirty eviction, 16 accumulator hit, 17 accumulator miss, 18 BTB hit, 19 micro-ITLB miss, 20 micro-DTLB miss. Codes 0x0-0x7, 0x14-0x19 and the duration codes 0x9 (bit 8), 0xB (bit 9), 0xD (bit 10) and 0xF (bit 11) add one on each enabled clock edge at which their source is high.
- R2: Occurrence codes 0x8 (bit 8), 0xA (bit 9), 0xC (bit 10), 0xE (bit 11), 0x10 (stall condition of R3) and 0x12 (access condition of R3) add one only on the first cycle the source is high after a cycle in which it was low.
- R3: The stall condition is bit 13 OR (bit 14 AND NOT bit 12). The access condition is bit 11 OR (bit 10 AND NOT bit 12). Code 0x11 counts the cycles of the stall condition and code 0x13 counts the cycles of the access condition.
- R4: Select codes 0x1A to 0x1F never change the count, whatever the raw inputs.
- R5: While the enable bit (control bit 8) is 0, no event changes the count.
- R6: A control write with bit 24 set zeroes the count at that edge and leaves the select field and the enable bit unchanged.
- R7: When the count wraps from all ones to zero, the overflow flag (control bit 16) is set and stays set. It is cleared only by a control write with bit 16 at 1. A control write with bit 16 at 0 leaves it set.
- R8: A control write that changes the select field arms the occurrence detector as if the new source had already been high. A condition that is already asserted when its code is selected adds nothing until it falls and rises again.
- R9: Address 0 is the control register: select in bits 4:0, enable in bit 8, overflow in bit 16. Address 1 is the count. A write to address 1 loads the count, and that load takes priority over an increment at the same edge.
- R10: After reset the select field, the enable bit, the overflow flag and the count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_evt | input | 21 | Raw event levels and pulses from the pipeline and the memory system |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 control, 1 count |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |

## Verification
The assertions check a set of rules on every cycle. The count never moves while the counter is disabled or a reserved code is selected. Without a register write it moves by at most one step. A clear command always leaves zero. A wrap always sets the overflow flag. In occurrence mode, a source that stays high never adds a second time. Only the directed scenarios can show whether each code is routed to the right raw bit, how the write trimming works out in the cache codes, and that a change of source while the condition is high is suppressed. They also show that the overflow flag survives a write of 0 and clears on a write of 1.

// File: rtl/perf_pkg.sv
package perf_pkg;

   localparam int RAW_N = 21;

   localparam int RAW_IC_MISS   = 0;
   localparam int RAW_FETCH_STL = 1;
   localparam int RAW_HAZARD    = 2;
   localparam int RAW_ITLB      = 3;
   localparam int RAW_DTLB      = 4;
   localparam int RAW_BRANCH    = 5;
   localparam int RAW_MISPRED   = 6;
   localparam int RAW_RETIRE    = 7;
   localparam int RAW_WBUF_FULL = 8;
   localparam int RAW_RD_MISS   = 9;
   localparam int RAW_WR_BUSY   = 10;
   localparam int RAW_RD_BUSY   = 11;
   localparam int RAW_WR_INBUF  = 12;
   localparam int RAW_RD_STALL  = 13;
   localparam int RAW_WR_STALL  = 14;
   localparam int RAW_DIRTY_EV  = 15;
   localparam int RAW_ACC_HIT   = 16;
   localparam int RAW_ACC_MISS  = 17;
   localparam int RAW_BTB_HIT   = 18;
   localparam int RAW_UITLB     = 19;
   localparam int RAW_UDTLB     = 20;

   localparam int NUM_CODES = 26;

   // control register bit positions
   localparam int CTL_EN_BIT  = 8;
   localparam int CTL_OVF_BIT = 16;
   localparam int CTL_CLR_BIT = 24;

   function automatic logic stall_cond(input logic [RAW_N-1:0] r);
      return r[RAW_RD_STALL] | (r[RAW_WR_STALL] & ~r[RAW_WR_INBUF]);
   endfunction

   function automatic logic access_cond(input logic [RAW_N-1:0] r);
      return r[RAW_RD_BUSY] | (r[RAW_WR_BUSY] & ~r[RAW_WR_INBUF]);
   endfunction

   function automatic logic code_cond(input int code, input logic [RAW_N-1:0] r);
      logic c;
      case (code)
         'h00: c = r[RAW_IC_MISS];
         'h01: c = r[RAW_FETCH_STL];
         'h02: c = r[RAW_HAZARD];
         'h03: c = r[RAW_ITLB];
         'h04: c = r[RAW_DTLB];
         'h05: c = r[RAW_BRANCH];
         'h06: c = r[RAW_MISPRED];
         'h07: c = r[RAW_RETIRE];
         'h08, 'h09: c = r[RAW_WBUF_FULL];
         'h0A, 'h0B: c = r[RAW_RD_MISS];
         'h0C, 'h0D: c = r[RAW_WR_BUSY];
         'h0E, 'h0F: c = r[RAW_RD_BUSY];
         'h10, 'h11: c = stall_cond(r);
         'h12, 'h13: c = access_cond(r);
         'h14: c = r[RAW_DIRTY_EV];
         'h15: c = r[RAW_ACC_HIT];
         'h16: c = r[RAW_ACC_MISS];
         'h17: c = r[RAW_BTB_HIT];
         'h18: c = r[RAW_UITLB];
         'h19: c = r[RAW_UDTLB];
         default: c = 1'b0;
      endcase
      return c;
   endfunction

   function automatic logic code_is_edge(input int code);
      return (code == 'h08) || (code == 'h0A) || (code == 'h0C) ||
             (code == 'h0E) || (code == 'h10) || (code == 'h12);
   endfunction

endpackage

// File: rtl/perf_event_sel.sv
module perf_event_sel
   import perf_pkg::*;
#(
   parameter int SEL_W = 5
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [RAW_N-1:0] raw,
   output logic             cond,
   output logic             edge_mode,
   output logic             legal
);
   localparam int SLOTS = 2 ** SEL_W;

   logic [SLOTS-1:0] cond_vec;
   logic [SLOTS-1:0] edge_vec;
   logic [SLOTS-1:0] legal_vec;

   generate
      if (SLOTS < NUM_CODES) begin : g_bad_sel
         $error("SEL_W too narrow for the event code space");
      end
      for (genvar c = 0; c < SLOTS; c++) begin : g_slot
         if (c < NUM_CODES) begin : g_code
            assign cond_vec[c]  = code_cond(c, raw);
            assign edge_vec[c]  = code_is_edge(c);
            assign legal_vec[c] = 1'b1;
         end else begin : g_rsvd
            assign cond_vec[c]  = 1'b0;
            assign edge_vec[c]  = 1'b0;
            assign legal_vec[c] = 1'b0;
         end
      end
   endgenerate

   assign legal     = legal_vec[sel];
   assign cond      = legal & cond_vec[sel];
   assign edge_mode = edge_vec[sel];

endmodule

// File: rtl/perf_occ_detect.sv
module perf_occ_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   input  logic edge_mode,
   input  logic rearm,
   output logic hit
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     prev_q <= 1'b0;
      else if (rearm) prev_q <= 1'b1;
      else            prev_q <= cond;
   end

   assign hit = edge_mode ? (cond & ~prev_q) : cond;

   // R2
   sustained_no_recount_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond && !rearm) ##1 (edge_mode && cond) |-> !hit);

   // R8
   rearm_blocks_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rearm |=> !(edge_mode && hit));

endmodule

// File: rtl/perf_count_reg.sv
module perf_count_reg #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             ovf_w1c,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic wrap;
   assign wrap = inc && !clr && !ld && (count == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (ld)  count <= ld_val;
      else if (inc) count <= count + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf <= 1'b0;
      else if (wrap)    ovf <= 1'b1;
      else if (ovf_w1c) ovf <= 1'b0;
   end

   // R7
   wrap_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && !ld && count == CNT_MAX) |=> (ovf && count == '0));

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_w1c) |=> ovf);

   // R6
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> count == '0);

   // R1
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !ld) |=> (count == $past(count) || count == $past(count) + 1'b1));

endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter
   import perf_pkg::*;
#(
   parameter int SEL_W  = 5,
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RAW_N-1:0]  raw_evt,
   input  logic              cfg_we,
   input  logic              cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata
);
   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie between 2 and DATA_W");
      end
      if (DATA_W <= CTL_CLR_BIT || SEL_W > CTL_EN_BIT) begin : g_bad_ctl
         $error("control layout does not fit DATA_W/SEL_W");
      end
   endgenerate

   logic [SEL_W-1:0] sel_q;
   logic             en_q;
   logic             ctl_wr, cnt_ld, clr_cmd, ctl_upd, sel_chg, ovf_w1c;
   logic             cond, edge_mode, legal, hit, inc;
   logic [CNT_W-1:0] count;
   logic             ovf;

   assign ctl_wr  = cfg_we && !cfg_addr;
   assign cnt_ld  = cfg_we &&  cfg_addr;
   assign clr_cmd = ctl_wr &&  cfg_wdata[CTL_CLR_BIT];
   assign ctl_upd = ctl_wr && !cfg_wdata[CTL_CLR_BIT];
   assign sel_chg = ctl_upd && (cfg_wdata[SEL_W-1:0] != sel_q);
   assign ovf_w1c = ctl_wr &&  cfg_wdata[CTL_OVF_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         en_q  <= 1'b0;
      end else if (ctl_upd) begin
         sel_q <= cfg_wdata[SEL_W-1:0];
         en_q  <= cfg_wdata[CTL_EN_BIT];
      end
   end

   perf_event_sel #(.SEL_W(SEL_W)) u_sel (
      .sel       (sel_q),
      .raw       (raw_evt),
      .cond      (cond),
      .edge_mode (edge_mode),
      .legal     (legal)
   );

   perf_occ_detect u_occ (
      .clk       (clk),
      .rst_n     (rst_n),
      .cond      (cond),
      .edge_mode (edge_mode),
      .rearm     (sel_chg),
      .hit       (hit)
   );

   assign inc = en_q && hit;

   perf_count_reg #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (inc),
      .clr     (clr_cmd),
      .ld      (cnt_ld),
      .ld_val  (cfg_wdata[CNT_W-1:0]),
      .ovf_w1c (ovf_w1c),
      .count   (count),
      .ovf     (ovf)
   );

   always_comb begin
      cfg_rdata = '0;
      if (cfg_addr) begin
         cfg_rdata[CNT_W-1:0] = count;
      end else begin
         cfg_rdata[SEL_W-1:0]   = sel_q;
         cfg_rdata[CTL_EN_BIT]  = en_q;
         cfg_rdata[CTL_OVF_BIT] = ovf;
      end
   end

   // R4
   reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!legal && !cfg_we) |=> count == $past(count));

   // R5
   disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !cfg_we) |=> count == $past(count));

   // R6
   clear_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cmd |=> (sel_q == $past(sel_q) && en_q == $past(en_q)));

   // R9
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_ld && !clr_cmd) |=> count == $past(cfg_wdata[CNT_W-1:0]));

endmodule

// File: tb/test_perf_event_counter.sv
`timescale 1ns/1ps
module test_perf_event_counter;
   localparam int RAWN = 21;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [RAWN-1:0]  raw_evt = '0;
   logic             cfg_we = 1'b0;
   logic             cfg_addr = 1'b0;
   logic [31:0]      cfg_wdata = '0;
   logic [31:0]      cfg_rdata;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #10 clk = ~clk;

   perf_event_counter i_perf_event_counter (
      .clk(clk), .rst_n(rst_n), .raw_evt(raw_evt), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata));

   function automatic logic [31:0] ctl(input int sel, input bit en);
      return (32'(sel) & 32'h1F) | (en ? 32'h100 : 32'h0);
   endfunction

   function automatic logic [RAWN-1:0] bitv(input int i);
      return RAWN'(1) << i;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input bit a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_wdata = '0;
   endtask

   task automatic rd(input bit a, output logic [31:0] d);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic hold(input logic [RAWN-1:0] v, input int n);
      raw_evt = v;
      repeat (n) @(negedge clk);
      raw_evt = '0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic clear_cnt();
      wr(1'b0, 32'h0100_0000);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(1'b0, d); chk("R10 control after reset", d, 32'h0);
      rd(1'b1, d); chk("R10 count after reset", d, 32'h0);
   endtask

   task automatic t_direct();
      logic [31:0] d;
      wr(1'b0, ctl('h07, 1)); clear_cnt();
      hold(bitv(7), 3); idle(); hold(bitv(7), 2);
      rd(1'b1, d); chk("R1 retire code 0x07", d, 32'd5);
      wr(1'b0, ctl('h17, 1)); clear_cnt();
      hold(bitv(18), 4); hold(bitv(17), 2);
      rd(1'b1, d); chk("R1 BTB hit code 0x17", d, 32'd4);
   endtask

   task automatic t_pairs();
      logic [31:0] d;
      wr(1'b0, ctl('h08, 1)); clear_cnt();
      hold(bitv(8), 4); idle(); hold(bitv(8), 1);
      rd(1'b1, d); chk("R2 write-buffer-full occurrences 0x08", d, 32'd2);
      wr(1'b0, ctl('h09, 1)); clear_cnt();
      hold(bitv(8), 4);
      rd(1'b1, d); chk("R1 write-buffer-full cycles 0x09", d, 32'd4);
      wr(1'b0, ctl('h12, 1)); clear_cnt();
      hold(bitv(11), 3); idle(); hold(bitv(10), 2);
      rd(1'b1, d); chk("R2 access occurrences 0x12", d, 32'd2);
   endtask

   task automatic t_trim();
      logic [31:0] d;
      wr(1'b0, ctl('h13, 1)); clear_cnt();
      hold(bitv(10), 2); hold(bitv(10) | bitv(12), 4); hold(bitv(11), 3);
      rd(1'b1, d); chk("R3 access cycles 0x13 with write trimming", d, 32'd5);
      wr(1'b0, ctl('h11, 1)); clear_cnt();
      hold(bitv(14), 1); hold(bitv(14) | bitv(12), 3); hold(bitv(13), 2);
      rd(1'b1, d); chk("R3 stall cycles 0x11 with write trimming", d, 32'd3);
   endtask

   task automatic t_reserved();
      logic [31:0] d;
      wr(1'b0, ctl('h1A, 1)); wr(1'b1, 32'd7);
      hold('1, 5);
      rd(1'b1, d); chk("R4 reserved code 0x1A", d, 32'd7);
      wr(1'b0, ctl('h1F, 1));
      hold('1, 5);
      rd(1'b1, d); chk("R4 reserved code 0x1F", d, 32'd7);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      wr(1'b0, ctl('h01, 0)); wr(1'b1, 32'd0);
      hold(bitv(1), 4);
      rd(1'b1, d); chk("R5 disabled counter holds", d, 32'd0);
      wr(1'b0, ctl('h01, 1));
      hold(bitv(1), 2);
      rd(1'b1, d); chk("R5 enabled counter resumes", d, 32'd2);
   endtask

   task automatic t_clear();
      logic [31:0] d;
      wr(1'b0, ctl('h05, 1)); wr(1'b1, 32'd0);
      hold(bitv(5), 3);
      rd(1'b1, d); chk("R1 branch code 0x05", d, 32'd3);
      clear_cnt();
      rd(1'b1, d); chk("R6 clear zeroes count", d, 32'd0);
      rd(1'b0, d); chk("R6 clear keeps select and enable", d, ctl('h05, 1));
   endtask

   task automatic t_wrap();
      logic [31:0] d;
      wr(1'b0, ctl('h01, 1)); wr(1'b1, 32'hFFFF_FFFE);
      hold(bitv(1), 1);
      rd(1'b0, d); chk("R7 no overflow before wrap", d[16], 32'd0);
      hold(bitv(1), 2);
      rd(1'b1, d); chk("R7 count after wrap", d, 32'd1);
      rd(1'b0, d); chk("R7 overflow set on wrap", d[16], 32'd1);
      wr(1'b0, ctl('h01, 1));
      rd(1'b0, d); chk("R7 overflow survives write of 0", d[16], 32'd1);
      wr(1'b0, ctl('h01, 1) | 32'h1_0000);
      rd(1'b0, d); chk("R7 overflow cleared by write of 1", d, ctl('h01, 1));
   endtask

   task automatic t_selchg();
      logic [31:0] d;
      wr(1'b0, ctl('h09, 1)); clear_cnt();
      raw_evt = bitv(9);
      wr(1'b0, ctl('h0A, 1));
      repeat (3) @(negedge clk);
      rd(1'b1, d); chk("R8 condition active at select change not counted", d, 32'd0);
      raw_evt = '0; idle();
      hold(bitv(9), 2);
      rd(1'b1, d); chk("R8 later rising edge counted", d, 32'd1);
   endtask

   task automatic t_load();
      logic [31:0] d;
      wr(1'b0, ctl('h01, 1));
      raw_evt = bitv(1);
      wr(1'b1, 32'd100);
      rd(1'b1, d); chk("R9 load wins over increment", d, 32'd100);
      idle();
      raw_evt = '0;
      rd(1'b1, d); chk("R9 counting continues after load", d, 32'd101);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      t_reset();
      t_direct();
      t_pairs();
      t_trim();
      t_reserved();
      t_enable();
      t_clear();
      t_wrap();
      t_selchg();
      t_load();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule